// File: doc/BRIEF.md
# Multi-word flash program sequencer

This block sits on the host side of a parallel flash bus and programs either two or four data words in one operation. A requester presents a mode bit (two-word or four-word), a base address and four data words. The sequencer writes a mode-specific command byte, then the data words to an aligned group of consecutive addresses, and then reads the device status byte over and over, one output-enable strobe per read, until the ready bit shows that the device has finished.

Once the device is ready, the error bits are examined in a fixed priority and folded into one result code. If the device reported an error, the sequencer writes a clear-status command before it reports completion, so the next request starts from clean device status. A poll limit ends an operation that never becomes ready with a timeout result. A suspend input holds the sequencer in a wait loop with no bus activity while it is polling, and polling carries on when the input is released.

Top module: `flash_mwp_seq`

## Requirements
- R1: After reset, busy, done, bus_we and bus_oe are all low.
- R2: A request with req_quad=0 produces, on consecutive write cycles, the command byte 30h (zero-extended), then req_data word 0 and word 1 (word k is bits k*DW and up).
- R3: A request with req_quad=1 produces the command byte 55h, then data words 0, 1, 2 and 3 in that order.
- R4: The command write goes to the aligned base address, and data word k goes to the aligned base with k in the low bits. Alignment clears bit 0 in two-word mode and bits 1 and 0 in four-word mode.
- R5: bus_we and bus_oe are never high in the same cycle. Each bus cycle lasts one clock.
- R6: After the last data write, status is read with single-cycle bus_oe pulses separated by at least one cycle with bus_oe low. Reads continue while status bit 7 is 0. With a device that becomes ready on read B+1, exactly B+1 reads are made when B+1 does not exceed the poll limit.
- R7: When status bit 7 is 1, result is 1 if bit 3 is set, else 2 if bit 4 is set, else 3 if bit 1 is set, else 0. Error bits in a status byte with bit 7 at 0 have no effect.
- R8: For results 1, 2 and 3, one extra write of byte 50h to the aligned base address follows the last status read, before done. No such write follows for results 0 and 4.
- R9: While suspend_req is high during polling, no status read is issued and busy stays high. Polling resumes after release, and the suspension does not count toward the poll limit.
- R10: If the status read that brings the count to POLL_LIMIT still has bit 7 at 0, the operation ends with result 4 and no further reads.
- R11: done is high for exactly one cycle per operation, with result valid in that cycle, and busy is low in the cycle after it. req_valid has no effect while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, taken when not busy |
| req_quad | input | 1 | 1 selects four-word mode, 0 selects two-word mode |
| req_addr | input | AW | Base address, low bits are forced to zero |
| req_data | input | 4*DW | Data words, word k at bits k*DW and up |
| suspend_req | input | 1 | Hold polling while high |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 supply invalid, 2 program fail, 3 protected, 4 timeout |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | DW | Flash write data |
| bus_we | output | 1 | Write strobe, one clock per write |
| bus_oe | output | 1 | Read strobe, one clock per read |
| bus_rdata | input | 8 | Status byte from the device, sampled at the end of a bus_oe cycle |

## Verification
The hardest case to reach from the ports is a suspension that lands in the middle of polling, together with its counterpart, readiness that arrives exactly on the last allowed read. The bench's device model stays busy for a programmable number of reads. In the directed case it raises suspend_req only after its own read counter shows that polling has begun, then checks that the count stays frozen for a long window. A separate pair of cases sets the busy length to one below and exactly at the poll limit, so both sides of the timeout boundary are covered. Randomized operations mix modes, misaligned addresses, error-bit patterns and busy lengths on either side of the limit.

// File: rtl/mwp_pkg.sv
package mwp_pkg;

  typedef enum logic [2:0] {
    RES_OK   = 3'd0,
    RES_VPP  = 3'd1,
    RES_PROG = 3'd2,
    RES_PROT = 3'd3,
    RES_TMO  = 3'd4
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WR, S_RD, S_EVAL, S_SUSP, S_CLR, S_FIN
  } st_e;

  localparam int STS_RDY  = 7;
  localparam int STS_VPP  = 3;
  localparam int STS_PRG  = 4;
  localparam int STS_PROT = 1;

endpackage

// File: rtl/mwp_status_decode.sv
module mwp_status_decode
  import mwp_pkg::*;
(
  input  logic [7:0] sts,
  output logic       ready,
  output res_e       code
);

  logic unused_sts;
  assign unused_sts = ^{sts[6:5], sts[2], sts[0]};

  assign ready = sts[STS_RDY];

  always_comb begin
    if (sts[STS_VPP])       code = RES_VPP;
    else if (sts[STS_PRG])  code = RES_PROG;
    else if (sts[STS_PROT]) code = RES_PROT;
    else                    code = RES_OK;
  end

endmodule

// File: rtl/mwp_poll_cnt.sv
module mwp_poll_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q >= CW'(LIMIT));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT)); // R10

endmodule

// File: rtl/mwp_fsm.sv
module mwp_fsm
  import mwp_pkg::*;
#(
  parameter int          AW      = 20,
  parameter int          DW      = 16,
  parameter logic [7:0]  OP_DUAL = 8'h30,
  parameter logic [7:0]  OP_QUAD = 8'h55,
  parameter logic [7:0]  OP_CLR  = 8'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_quad,
  input  logic [AW-1:0] req_addr,
  input  logic [4*DW-1:0] req_data,
  input  logic          suspend_req,
  input  logic [7:0]    bus_rdata,
  input  logic          sts_ready,
  input  res_e          sts_code,
  input  logic          cnt_expired,
  output logic [7:0]    sts_byte,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic          busy,
  output logic          done,
  output res_e          result,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_oe
);

  localparam int PADW = DW - 8;

  st_e             st_q, st_d;
  logic [1:0]      idx_q, idx_d;
  res_e            res_q, res_d;
  logic [7:0]      sts_q;
  logic            quad_q;
  logic [AW-1:0]   base_q;
  logic [DW-1:0]   data_q [4];
  logic            load, sts_ld;
  logic [1:0]      last_idx;
  logic [AW-1:0]   base_al;

  assign last_idx = quad_q ? 2'd3 : 2'd1;
  assign base_al  = {req_addr[AW-1:2], (req_quad ? 1'b0 : req_addr[1]), 1'b0};

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    res_d  = res_q;
    load   = 1'b0;
    sts_ld = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        load  = 1'b1;
        idx_d = 2'd0;
        st_d  = S_CMD;
      end
      S_CMD:  st_d = S_WR;
      S_WR: begin
        if (idx_q == last_idx) st_d = S_RD;
        else                   idx_d = idx_q + 2'd1;
      end
      S_RD: begin
        sts_ld = 1'b1;
        st_d   = S_EVAL;
      end
      S_EVAL: begin
        if (sts_ready) begin
          res_d = sts_code;
          st_d  = (sts_code == RES_OK) ? S_FIN : S_CLR;
        end else if (cnt_expired) begin
          res_d = RES_TMO;
          st_d  = S_FIN;
        end else if (suspend_req) begin
          st_d  = S_SUSP;
        end else begin
          st_d  = S_RD;
        end
      end
      S_SUSP: if (!suspend_req) st_d = S_RD;
      S_CLR:  st_d = S_FIN;
      S_FIN:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= 2'd0;
      res_q <= RES_OK;
      sts_q <= 8'h00;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      res_q <= res_d;
      if (sts_ld) sts_q <= bus_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      quad_q <= req_quad;
      base_q <= base_al;
      for (int k = 0; k < 4; k++) data_q[k] <= req_data[k*DW +: DW];
    end
  end

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    case (st_q)
      S_CMD: begin
        bus_addr  = base_q;
        bus_wdata = {{PADW{1'b0}}, (quad_q ? OP_QUAD : OP_DUAL)};
      end
      S_WR: begin
        bus_addr  = {base_q[AW-1:2], base_q[1:0] | idx_q};
        bus_wdata = data_q[idx_q];
      end
      S_CLR: begin
        bus_addr  = base_q;
        bus_wdata = {{PADW{1'b0}}, OP_CLR};
      end
      default: ;
    endcase
  end

  assign bus_we   = (st_q == S_CMD) || (st_q == S_WR) || (st_q == S_CLR);
  assign bus_oe   = (st_q == S_RD);
  assign busy     = (st_q != S_IDLE);
  assign done     = (st_q == S_FIN);
  assign result   = res_q;
  assign sts_byte = sts_q;
  assign cnt_clr  = (st_q == S_CMD);
  assign cnt_inc  = (st_q == S_RD);

  AST_OE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |=> !bus_oe); // R6

  AST_CLR_BEFORE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (res_q inside {RES_VPP, RES_PROG, RES_PROT})) |->
      ($past(bus_we) && ($past(bus_wdata[7:0]) == OP_CLR))); // R8

  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_SUSP) && suspend_req) |=> !bus_oe && busy); // R9

endmodule

// File: rtl/flash_mwp_seq.sv
module flash_mwp_seq
  import mwp_pkg::*;
#(
  parameter int          AW         = 20,
  parameter int          DW         = 16,
  parameter int unsigned POLL_LIMIT = 16,
  parameter logic [7:0]  OP_DUAL    = 8'h30,
  parameter logic [7:0]  OP_QUAD    = 8'h55,
  parameter logic [7:0]  OP_CLR     = 8'h50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_quad,
  input  logic [AW-1:0]   req_addr,
  input  logic [4*DW-1:0] req_data,
  input  logic            suspend_req,
  output logic            busy,
  output logic            done,
  output logic [2:0]      result,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            bus_we,
  output logic            bus_oe,
  input  logic [7:0]      bus_rdata
);

  logic [7:0] sts_byte;
  logic       sts_ready;
  res_e       sts_code;
  res_e       res;
  logic       cnt_clr, cnt_inc, cnt_expired;

  mwp_status_decode u_dec (
    .sts   (sts_byte),
    .ready (sts_ready),
    .code  (sts_code)
  );

  mwp_poll_cnt #(.LIMIT(POLL_LIMIT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .expired (cnt_expired)
  );

  mwp_fsm #(
    .AW(AW), .DW(DW), .OP_DUAL(OP_DUAL), .OP_QUAD(OP_QUAD), .OP_CLR(OP_CLR)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_quad    (req_quad),
    .req_addr    (req_addr),
    .req_data    (req_data),
    .suspend_req (suspend_req),
    .bus_rdata   (bus_rdata),
    .sts_ready   (sts_ready),
    .sts_code    (sts_code),
    .cnt_expired (cnt_expired),
    .sts_byte    (sts_byte),
    .cnt_clr     (cnt_clr),
    .cnt_inc     (cnt_inc),
    .busy        (busy),
    .done        (done),
    .result      (res),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .bus_oe      (bus_oe)
  );

  assign result = res;

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_oe)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_we && !bus_oe && !done)); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R11

  AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result <= 3'd4)); // R7

endmodule

// File: tb/sim_flash_mwp_seq.sv
module sim_flash_mwp_seq;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int L  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_quad = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [4*DW-1:0] req_data = '0;
  logic            suspend_req = 1'b0;
  logic            busy, done, bus_we, bus_oe;
  logic [2:0]      result;
  logic [AW-1:0]   bus_addr;
  logic [DW-1:0]   bus_wdata;
  logic [7:0]      bus_rdata;

  always #10 clk = ~clk;

  flash_mwp_seq #(.AW(AW), .DW(DW), .POLL_LIMIT(L)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_quad(req_quad),
    .req_addr(req_addr), .req_data(req_data), .suspend_req(suspend_req),
    .busy(busy), .done(done), .result(result), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_oe(bus_oe), .bus_rdata(bus_rdata)
  );

  // device model
  logic [AW-1:0] log_a [1024];
  logic [DW-1:0] log_d [1024];
  int            nlog = 0;
  int            rd_cnt = 0;
  int            rd_base = 0;
  int            busy_reads = 0;
  logic [7:0]    err_bits = 8'h00;

  always @(posedge clk) begin
    if (bus_we && nlog < 1024) begin
      log_a[nlog] <= bus_addr;
      log_d[nlog] <= bus_wdata;
      nlog <= nlog + 1;
    end
    if (bus_oe) rd_cnt <= rd_cnt + 1;
  end

  always_comb begin
    if (!bus_oe)                             bus_rdata = 8'h00;
    else if ((rd_cnt - rd_base) >= busy_reads) bus_rdata = 8'h80 | err_bits;
    else                                     bus_rdata = {1'b0, err_bits[6:0]};
  end

  int ncheck = 0;
  int nfail  = 0;
  int cycles = 0;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    ncheck++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_res(input logic [7:0] e, input int b);
    if (b + 1 > L) return 4;
    if (e[3]) return 1;
    if (e[4]) return 2;
    if (e[1]) return 3;
    return 0;
  endfunction

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic do_op(input bit quad, input logic [AW-1:0] a, input logic [4*DW-1:0] d,
                       input int b, input logic [7:0] e, input bit poke);
    int lbase, n, nw, er, rexp;
    bit seen;
    logic [AW-1:0] al;
    err_bits   = e;
    busy_reads = b;
    rd_base    = rd_cnt;
    lbase      = nlog;
    @(negedge clk);
    req_quad = quad; req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      req_quad = ~quad; req_addr = ~a; req_data = ~d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_done(seen);
    chk(seen, "R11 done seen", seen, 1);
    er = exp_res(e, b);
    chk(result == 3'(er), "R7 result", result, er);
    n  = quad ? 4 : 2;
    al = quad ? {a[AW-1:2], 2'b00} : {a[AW-1:1], 1'b0};
    nw = n + 1 + ((er >= 1 && er <= 3) ? 1 : 0);
    chk(nlog - lbase == nw, "R8 write count", nlog - lbase, nw);
    if (nlog - lbase == nw) begin
      chk(log_a[lbase] == al, "R4 cmd addr", log_a[lbase], al);
      chk(log_d[lbase] == (quad ? 16'h0055 : 16'h0030),
          quad ? "R3 cmd byte" : "R2 cmd byte", log_d[lbase], quad ? 16'h55 : 16'h30);
      for (int k = 0; k < n; k++) begin
        chk(log_a[lbase+1+k] == (al | AW'(k)), "R4 word addr", log_a[lbase+1+k], al | AW'(k));
        chk(log_d[lbase+1+k] == d[k*DW +: DW], quad ? "R3 word data" : "R2 word data",
            log_d[lbase+1+k], d[k*DW +: DW]);
      end
      if (nw == n + 2) begin
        chk(log_a[lbase+n+1] == al, "R8 clear addr", log_a[lbase+n+1], al);
        chk(log_d[lbase+n+1] == 16'h0050, "R8 clear byte", log_d[lbase+n+1], 16'h50);
      end
    end
    rexp = (b + 1 > L) ? L : b + 1;
    chk(rd_cnt - rd_base == rexp, (b + 1 > L) ? "R10 read count" : "R6 read count",
        rd_cnt - rd_base, rexp);
    @(negedge clk);
    chk(!done && !busy, "R11 done pulse then idle", {done, busy}, 0);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", ncheck - nfail, ncheck);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    chk(1'b0, "watchdog", cycles, 0);
    summary();
  end

  initial begin
    int snap, lb;
    bit seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_we && !bus_oe, "R1 reset state",
        {busy, done, bus_we, bus_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_we && !bus_oe, "R1 idle after reset", {busy, bus_we, bus_oe}, 0);

    do_op(1'b0, 20'h12343, 64'h4444_3333_2222_1111, 0, 8'h00, 1'b0);
    do_op(1'b1, 20'h0ABC7, 64'hDDDD_CCCC_BBBB_AAAA, 3, 8'h00, 1'b0);
    do_op(1'b1, 20'hFFFFF, 64'h0123_4567_89AB_CDEF, L - 1, 8'h00, 1'b0);
    do_op(1'b0, 20'h00001, 64'h1, L, 8'h00, 1'b0);
    do_op(1'b0, 20'h55555, 64'h2, 2, 8'h08, 1'b0);
    do_op(1'b1, 20'h00002, 64'h3, 1, 8'h10, 1'b0);
    do_op(1'b0, 20'h7FFFE, 64'h4, 0, 8'h02, 1'b0);
    do_op(1'b1, 20'h00003, 64'h5, 4, 8'h1A, 1'b0);
    do_op(1'b0, 20'h00005, 64'h6, 2, 8'h12, 1'b0);
    do_op(1'b1, 20'h31337, 64'h7, L + 5, 8'h1A, 1'b0);
    do_op(1'b1, 20'h40001, 64'hFEED_BEEF_CAFE_F00D, 5, 8'h00, 1'b1);

    // R11: no activity after an ignored busy request
    lb = nlog;
    repeat (10) @(negedge clk);
    chk(nlog == lb && !busy, "R11 ignored request left no op", nlog - lb, 0);

    // R9: suspension in the middle of polling
    err_bits = 8'h00; busy_reads = 10; rd_base = rd_cnt; lb = nlog;
    @(negedge clk);
    req_quad = 1'b1; req_addr = 20'h22220; req_data = 64'h9; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && (rd_cnt - rd_base) < 2; i++) @(negedge clk);
    suspend_req = 1'b1;
    repeat (4) @(negedge clk);
    snap = rd_cnt;
    repeat (40) @(negedge clk);
    chk(rd_cnt == snap, "R9 no reads while suspended", rd_cnt - snap, 0);
    chk(busy && !done, "R9 busy held while suspended", {busy, done}, 2'b10);
    suspend_req = 1'b0;
    wait_done(seen);
    chk(seen && result == 3'd0, "R9 resumes and finishes ok", result, 0);
    chk(rd_cnt - rd_base == 11, "R9 read count after resume", rd_cnt - rd_base, 11);
    @(negedge clk);

    for (int t = 0; t < 30; t++) begin
      logic [7:0] e;
      e = 8'($urandom) & 8'h7F;
      do_op(1'($urandom), 20'($urandom), {$urandom, $urandom},
            int'($urandom % 21), e, 1'($urandom % 4 == 0));
    end

    summary();
  end

endmodule